// File: doc/BRIEF.md
# Jet Element Decoder and Half-Width Multiplexer

This block sits between a bank of input deserialisers and a jet processor. Each bunch crossing it receives one 10-bit word from an electromagnetic channel and one from a hadronic channel for every tower position. It checks the odd parity of each word and drops the parity bit to recover a 9-bit energy. It then adds the two energies of a position into a 10-bit jet element that carries no parity.

Elements go downstream in two ways. A full-width copy is held for the whole bunch. A 5-bit lane per element runs at twice the bunch rate and carries the low half of the element and then the high half. The block runs on the double-rate clock. A phase input marks the edge where a new bunch is captured. A parity failure or a link error on either word of a pair blanks that element for the bunch and raises a per-pair flag. The fault is also latched into a sticky bit per input channel, which stays set until the matching clear bit is pulsed.

Top module: `elem_mux`

## Requirements
- R1: While reset is held, and at the first edge after it, every element, lane, per-pair flag and sticky bit reads zero.
- R2: A word is valid when the XOR of all its 10 bits is 1 (odd parity in bit 0), and its energy is bits 9:1. For a valid pair with no link error, the element equals the sum of the two 9-bit energies. The largest result is 1022, which fits in 10 bits without wrapping.
- R3: Inputs are captured only at a clock edge where `phase_i` is 1. `elem_o` takes the new values at that edge and holds them through the following edges where `phase_i` is 0.
- R4: After a capture edge, `lane_o` for each pair shows element bits 4:0. After the next edge, where `phase_i` is 0, it shows bits 9:5.
- R5: A parity failure on either word of a pair makes that element zero and sets its bit in `bad_o` for that bunch. The other pairs are not affected.
- R6: An asserted link-error flag on either channel of a pair has the same effect as a parity failure.
- R7: A fault on a channel at a capture edge sets that channel's sticky bit. The bit stays set until its clear bit is high at an edge. When a fault and a clear hit the same channel at the same capture edge, the bit ends up set.
- R8: A clear bit resets only its own channel's sticky bit.
- R9: Input words and link flags present at edges where `phase_i` is 0 have no effect on `elem_o`, `bad_o` or the sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| phase_i | input | 1 | 1 marks the capture edge of a bunch; 0 marks the second half |
| em_i | input | NPAIR*10 | Electromagnetic words, pair i at bits 10i+9:10i |
| had_i | input | NPAIR*10 | Hadronic words, same packing |
| em_lerr_i | input | NPAIR | Link-error flag per electromagnetic channel |
| had_lerr_i | input | NPAIR | Link-error flag per hadronic channel |
| clr_em_i | input | NPAIR | Clears the electromagnetic sticky bits |
| clr_had_i | input | NPAIR | Clears the hadronic sticky bits |
| elem_o | output | NPAIR*10 | Full-width jet elements |
| lane_o | output | NPAIR*5 | Half-width lanes, pair i at bits 5i+4:5i |
| bad_o | output | NPAIR | Pair blanked in the current bunch |
| stk_em_o | output | NPAIR | Sticky fault bits, electromagnetic channels |
| stk_had_o | output | NPAIR | Sticky fault bits, hadronic channels |

## Verification
The lane checks tie the value of `lane_o` to the phase seen at the previous edge. They do not require the phase to alternate strictly, because a run of phase-0 edges simply keeps the high half on the lane. The sticky-hold check assumes the clear inputs are sampled at every edge and are not tied to the phase. The stimulus changes inputs only one time unit after a rising edge and holds them steady until the next edge. It raises `phase_i` for exactly one edge per bunch, and idle stretches leave the phase at 0.

// File: rtl/elem_mux.sv
module elem_mux #(
  parameter int NPAIR = 12,
  parameter int WW    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phase_i,
  input  logic [NPAIR*WW-1:0] em_i,
  input  logic [NPAIR*WW-1:0] had_i,
  input  logic [NPAIR-1:0]    em_lerr_i,
  input  logic [NPAIR-1:0]    had_lerr_i,
  input  logic [NPAIR-1:0]    clr_em_i,
  input  logic [NPAIR-1:0]    clr_had_i,
  output logic [NPAIR*WW-1:0] elem_o,
  output logic [NPAIR*HW-1:0] lane_o,
  output logic [NPAIR-1:0]    bad_o,
  output logic [NPAIR-1:0]    stk_em_o,
  output logic [NPAIR-1:0]    stk_had_o
);
  localparam int HW   = WW / 2;
  localparam int EMAX = 2 * ((1 << (WW - 1)) - 1);

  logic [NPAIR-1:0]    em_ok, had_ok;
  logic [NPAIR*WW-1:0] nxt;
  logic [NPAIR*HW-1:0] lo_nxt, hi_cur;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic [WW-1:0] ew, hw;
    assign ew = em_i[i*WW +: WW];
    assign hw = had_i[i*WW +: WW];
    assign em_ok[i]  = (^ew) & ~em_lerr_i[i];
    assign had_ok[i] = (^hw) & ~had_lerr_i[i];
    assign nxt[i*WW +: WW] = (em_ok[i] & had_ok[i])
                           ? ({1'b0, ew[WW-1:1]} + {1'b0, hw[WW-1:1]})
                           : '0;
    assign lo_nxt[i*HW +: HW] = nxt[i*WW +: HW];
    assign hi_cur[i*HW +: HW] = elem_o[i*WW+HW +: HW];

    always @(posedge clk) begin
      if (rst_n) begin
        a_r5_bad_blanks: assert (!bad_o[i] || elem_o[i*WW +: WW] == '0)
          else $error("blanked pair %0d carries data", i);
        a_r2_sum_range: assert (elem_o[i*WW +: WW] <= WW'(EMAX))
          else $error("pair %0d element above maximum", i);
      end
    end

    a_r4_lane_lo: assert property (@(posedge clk) disable iff (!rst_n)
      phase_i |=> lane_o[i*HW +: HW] == elem_o[i*WW +: HW]);
    a_r4_lane_hi: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_i |=> lane_o[i*HW +: HW] == elem_o[i*WW+HW +: HW]);
    a_r7_sticky_hold_em: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_em_o[i] && !clr_em_i[i]) |=> stk_em_o[i]);
    a_r7_sticky_hold_had: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_had_o[i] && !clr_had_i[i]) |=> stk_had_o[i]);
    a_r7_bad_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_o[i]) |-> (stk_em_o[i] || stk_had_o[i]));
  end

  a_r9_hold_elem: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_i |=> ($stable(elem_o) && $stable(bad_o)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_o    <= '0;
      lane_o    <= '0;
      bad_o     <= '0;
      stk_em_o  <= '0;
      stk_had_o <= '0;
    end else begin
      stk_em_o  <= (stk_em_o  & ~clr_em_i)  | (phase_i ? ~em_ok  : '0);
      stk_had_o <= (stk_had_o & ~clr_had_i) | (phase_i ? ~had_ok : '0);
      if (phase_i) begin
        elem_o <= nxt;
        bad_o  <= ~(em_ok & had_ok);
        lane_o <= lo_nxt;
      end else begin
        lane_o <= hi_cur;
      end
    end
  end
endmodule

// File: tb/sim_elem_mux.sv
module sim_elem_mux;
  localparam int NP = 12;
  localparam int W  = 10;

  logic clk = 0, rst_n = 0, phase = 0;
  logic [NP*W-1:0] em = '0, had = '0;
  logic [NP-1:0] eml = '0, hal = '0, cle = '0, clh = '0;
  logic [NP*W-1:0] elem;
  logic [NP*5-1:0] lane;
  logic [NP-1:0] bad, sem, shd;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [8:0] ee [NP];
  logic [8:0] he [NP];
  logic [NP-1:0] pe_bad, ph_bad;
  logic [NP-1:0] x_se = '0, x_sh = '0;
  logic [NP*W-1:0] x_elem;
  logic [NP-1:0] x_bad;

  always #2 clk = ~clk;

  elem_mux #(.NPAIR(NP), .WW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .em_i(em), .had_i(had),
    .em_lerr_i(eml), .had_lerr_i(hal), .clr_em_i(cle), .clr_had_i(clh),
    .elem_o(elem), .lane_o(lane), .bad_o(bad), .stk_em_o(sem), .stk_had_o(shd));

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkword(input logic [8:0] e, input logic badp);
    return {e, badp ? (^e) : ~(^e)};
  endfunction

  function automatic logic [NP*5-1:0] halves(input logic [NP*W-1:0] v, input bit hi);
    logic [NP*5-1:0] r;
    for (int i = 0; i < NP; i++) r[i*5 +: 5] = hi ? v[i*W+5 +: 5] : v[i*W +: 5];
    return r;
  endfunction

  // Drives one bunch from ee/he/pe_bad/ph_bad/eml/hal, with optional clears at capture.
  task automatic run_bunch(input logic [NP-1:0] ce, input logic [NP-1:0] ch, input string tag);
    logic [NP-1:0] fe, fh;
    for (int i = 0; i < NP; i++) begin
      em[i*W +: W]  = mkword(ee[i], pe_bad[i]);
      had[i*W +: W] = mkword(he[i], ph_bad[i]);
    end
    fe = pe_bad | eml;
    fh = ph_bad | hal;
    x_bad = fe | fh;
    for (int i = 0; i < NP; i++)
      x_elem[i*W +: W] = x_bad[i] ? 10'd0 : ({1'b0, ee[i]} + {1'b0, he[i]});
    x_se = (x_se & ~ce) | fe;
    x_sh = (x_sh & ~ch) | fh;
    cle = ce; clh = ch; phase = 1;
    tick;
    cle = '0; clh = '0; phase = 0;
    chk({tag, " R2/R3 elem"}, 128'(elem), 128'(x_elem));
    chk({tag, " R5/R6 bad"}, 128'(bad), 128'(x_bad));
    chk({tag, " R4 lane low half"}, 128'(lane), 128'(halves(x_elem, 0)));
    chk({tag, " R7 sticky em"}, 128'(sem), 128'(x_se));
    chk({tag, " R7 sticky had"}, 128'(shd), 128'(x_sh));
    tick;
    chk({tag, " R4 lane high half"}, 128'(lane), 128'(halves(x_elem, 1)));
    chk({tag, " R3 elem held"}, 128'(elem), 128'(x_elem));
  endtask

  task automatic clear_flags;
    for (int i = 0; i < NP; i++) begin ee[i] = '0; he[i] = '0; end
    pe_bad = '0; ph_bad = '0; eml = '0; hal = '0;
  endtask

  task automatic t_reset;
    chk("R1 elem", 128'(elem), 0);
    chk("R1 lane", 128'(lane), 0);
    chk("R1 bad", 128'(bad), 0);
    chk("R1 sticky", 128'({sem, shd}), 0);
  endtask

  task automatic t_sums;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(i*41 + 3); he[i] = 9'(500 - i*37); end
    run_bunch('0, '0, "sums");
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(i*i + 1); he[i] = 9'(i ^ 9'h155); end
    run_bunch('0, '0, "pattern");
  endtask

  task automatic t_max;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'd511; he[i] = 9'd511; end
    run_bunch('0, '0, "R2 max 1022");
    chk("R2 max element", 128'(elem[W-1:0]), 128'(10'd1022));
  endtask

  task automatic t_parity;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(100 + i); he[i] = 9'(7 * i); end
    pe_bad[3] = 1; ph_bad[7] = 1;
    run_bunch('0, '0, "R5 parity");
  endtask

  task automatic t_lerr;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(60 + i); he[i] = 9'(200 - i); end
    eml[5] = 1; hal[9] = 1;
    run_bunch('0, '0, "R6 link error");
    eml = '0; hal = '0;
  endtask

  task automatic t_ignore;
    logic [NP*W-1:0] held;
    logic [NP-1:0] hb;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(30 * i); he[i] = 9'(12); end
    run_bunch('0, '0, "R9 setup");
    held = elem; hb = bad;
    for (int i = 0; i < NP; i++) em[i*W +: W] = mkword(9'(i), 1'b1);
    eml = '1; hal = '1;
    tick;
    chk("R9 elem unchanged", 128'(elem), 128'(held));
    chk("R9 bad unchanged", 128'(bad), 128'(hb));
    chk("R9 sticky unchanged", 128'({sem, shd}), 128'({x_se, x_sh}));
    eml = '0; hal = '0;
  endtask

  task automatic t_clear;
    cle = '0; cle[3] = 1;
    tick;
    cle = '0;
    x_se[3] = 0;
    chk("R8 em clear only own bit", 128'(sem), 128'(x_se));
    chk("R8 had untouched", 128'(shd), 128'(x_sh));
    clh = '1;
    tick;
    clh = '0;
    x_sh = '0;
    chk("R7 had cleared", 128'(shd), 0);
  endtask

  task automatic t_set_wins;
    logic [NP-1:0] c;
    clear_flags();
    for (int i = 0; i < NP; i++) begin ee[i] = 9'(i); he[i] = 9'(i); end
    pe_bad[2] = 1;
    c = '0; c[2] = 1; c[4] = 1;
    run_bunch(c, '0, "R7 set beats clear");
    chk("R7 set wins bit", 128'(sem[2]), 1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    t_reset();
    rst_n = 1;
    tick;
    t_reset();
    t_sums();
    t_max();
    t_parity();
    t_lerr();
    t_ignore();
    t_clear();
    t_set_wins();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule